// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block is a first-in first-out buffer for 36-bit words that sits between two independent clock domains. The writer pushes words on its own clock and the reader pops them on another. The depth is chosen at build time as 256 or 1024 words. The block reports its fill state through four active-low flags. A full flag and a programmable almost-full flag are timed to the write clock. A programmable almost-empty flag and an empty indication are timed to the read clock.

Each side keeps a binary pointer that is one bit wider than the address. The pointer crosses to the other side as Gray code through two flip-flop stages. A flag that a remote access would release therefore changes on the second rising edge of its own clock after that access. A flag that a local access would assert changes at once. A read copies the addressed word into an output register on the read edge, and from that edge the word no longer counts toward the fill level.

The almost-empty threshold X and the almost-full threshold Y sit in offset registers. Reset loads these registers with parameter presets. The write side can also load both registers in one cycle by raising a load strobe, and the new values then come from two fields of the write data bus.

Top module: `dual_clock_fifo_flags`

## Requirements
- R1: When `fullN` is low the array holds DEPTH words. A write attempted while `fullN` is low is discarded: the stored contents, the pointers and the flags do not change.
- R2: After a read frees a location in a full array, `fullN` goes high on the second rising edge of `wrClk` after the read edge, and not before.
- R3: Each accepted write (`wrEn` high, `offLoad` low, `fullN` high) stores `wrData` and adds exactly one word. Words leave the block in the order they were written.
- R4: `almostEmptyN` is low when the read-side word count is X or less, and high when the count is X+1 or more. The count seen on the read side includes a write from the second rising edge of `rdClk` after that write.
- R5: `almostFullN` is low when the write-side word count is DEPTH-Y or more, and high when the count is DEPTH-(Y+1) or less. A read is reflected on the second rising edge of `wrClk` after that read.
- R6: `emptyN` is low exactly when the read-side count is zero. A read attempted while `emptyN` is low is ignored.
- R7: An accepted read (`rdEn` high, `emptyN` high) places the oldest word on `rdData` on that `rdClk` edge, and `rdData` holds that word until the next accepted read. A word that has moved to `rdData` no longer counts toward the fill level.
- R8: An active-low reset clears both pointers and `rdData`. It drives `fullN` high, `emptyN` low, `almostEmptyN` low and `almostFullN` high, and it loads X with AE_PRESET and Y with AF_PRESET.
- R9: On a `wrClk` edge with `offLoad` high, X is loaded from `wrData[AW-1:0]` and Y is loaded from `wrData[18+AW-1:18]`, where AW = log2(DEPTH). No word is written on that edge.
- R10: DEPTH is 256 or 1024, and words are 36 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrEn | input | 1 | Write request |
| wrData | input | 36 | Write word, and the offset fields when `offLoad` is high |
| offLoad | input | 1 | Load both offset registers from `wrData` |
| rdEn | input | 1 | Read request |
| rdData | output | 36 | Output register holding the last word read |
| fullN | output | 1 | Low when full (write clock) |
| almostFullN | output | 1 | Low when the count is at least DEPTH-Y (write clock) |
| almostEmptyN | output | 1 | Low when the count is X or less (read clock) |
| emptyN | output | 1 | Low when empty (read clock) |

## Verification
A write and a read can land on the same edge. When they do, each flag must follow its own side's pointer at once and the other side's pointer only after two edges. The bench provokes this around the full point, the empty point and both thresholds. It does so with long random traffic that requests writes and reads together, and with directed single reads from a full array and single writes into an empty one. A reference model that uses queues and delay stages compares every flag and `rdData` on every clock.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  // Per-edge strobes issued by the control to the storage.
  typedef struct packed {
    logic wrStrobe; // store a word at the write address
    logic rdStrobe; // move the word at the read address to the output register
  } fifo_strobe_t;
endpackage

// File: rtl/fifo_dpath.sv
module fifo_dpath
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifo_strobe_t     strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdStrobe) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int AE_PRESET = 8,
  parameter int AF_PRESET = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          offLoad,
  input  logic [AW-1:0] aeField,
  input  logic [AW-1:0] afField,
  output fifo_strobe_t  strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          almostFullN,
  output logic          almostEmptyN,
  output logic          emptyN
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // Offset registers (write domain; the read side treats X as quasi-static)
  logic [AW-1:0] aeOff, afOff;
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= AW'(AE_PRESET);
      afOff <= AW'(AF_PRESET);
    end else if (offLoad) begin
      aeOff <= aeField;
      afOff <= afField;
    end
  end

  // Write side
  logic [PW-1:0] wrBin, wrGray, rdSyncA, rdSyncB, wrCount, afLimit;
  logic          wrGo;

  assign wrCount     = wrBin - fromGray(rdSyncB);
  assign afLimit     = PW'(DEPTH) - {1'b0, afOff};
  assign fullN       = (wrCount < PW'(DEPTH));
  assign almostFullN = (wrCount < afLimit);
  assign wrGo        = wrEn && !offLoad && fullN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin   <= '0;
      wrGray  <= '0;
      rdSyncA <= '0;
      rdSyncB <= '0;
    end else begin
      rdSyncA <= rdGrayQ;
      rdSyncB <= rdSyncA;
      if (wrGo) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= toGray(wrBin + 1'b1);
      end
    end
  end

  // Read side
  logic [PW-1:0] rdBin, rdGrayQ, wrSyncA, wrSyncB, rdCount;
  logic          rdGo;

  assign rdCount      = fromGray(wrSyncB) - rdBin;
  assign emptyN       = (rdCount != '0);
  assign almostEmptyN = (rdCount > {1'b0, aeOff});
  assign rdGo         = rdEn && emptyN;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin   <= '0;
      rdGrayQ <= '0;
      wrSyncA <= '0;
      wrSyncB <= '0;
    end else begin
      wrSyncA <= wrGray;
      wrSyncB <= wrSyncA;
      if (rdGo) begin
        rdBin   <= rdBin + 1'b1;
        rdGrayQ <= toGray(rdBin + 1'b1);
      end
    end
  end

  assign strobe.wrStrobe = wrGo;
  assign strobe.rdStrobe = rdGo;
  assign wrAddr = wrBin[AW-1:0];
  assign rdAddr = rdBin[AW-1:0];

  // R1: a write attempted while full leaves the write pointer unchanged
  a_r1_no_write_when_full: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && wrEn) |=> $stable(wrBin));

  // R3: the write pointer moves by at most one word per edge
  a_r3_single_step: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrBin != $past(wrBin)) |-> (wrBin == $past(wrBin) + 1'b1));

  // R3: the Gray copy that crosses domains changes at most one bit per edge
  a_r3_gray_one_bit: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  // R6: a read attempted while empty leaves the read pointer unchanged
  a_r6_no_read_when_empty: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && rdEn) |=> $stable(rdBin));

  // R5: a full array is always almost full
  a_r5_full_in_af: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |-> !almostFullN);

  // R4: an empty array is always almost empty
  a_r4_empty_in_ae: assert property (@(posedge rdClk) disable iff (!rstN)
    !emptyN |-> !almostEmptyN);
endmodule

// File: rtl/dual_clock_fifo_flags.sv
module dual_clock_fifo_flags
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH     = 256,
  parameter int WIDTH     = 36,
  parameter int AE_PRESET = 8,
  parameter int AF_PRESET = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int AF_LSB = WIDTH / 2
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             offLoad,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             fullN,
  output logic             almostFullN,
  output logic             almostEmptyN,
  output logic             emptyN
);
  // R10: only the two supported depths
  initial a_r10_depth: assert (DEPTH == 256 || DEPTH == 1024);

  fifo_strobe_t  strobe;
  logic [AW-1:0] wrAddr, rdAddr;

  fifo_ctrl #(.DEPTH(DEPTH), .AE_PRESET(AE_PRESET), .AF_PRESET(AF_PRESET)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn), .offLoad(offLoad),
    .aeField(wrData[AW-1:0]), .afField(wrData[AF_LSB+AW-1:AF_LSB]),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN), .emptyN(emptyN)
  );

  fifo_dpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/dual_clock_fifo_flags_test.sv
module dual_clock_fifo_flags_test;
  localparam int DEPTH = 256;
  localparam int WIDTH = 36;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, offLoad = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic fullN, almostFullN, almostEmptyN, emptyN;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz, both sides share it

  dual_clock_fifo_flags #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AE_PRESET(8), .AF_PRESET(8)) uut (
    .wrClk(clk), .rdClk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .offLoad(offLoad), .rdEn(rdEn),
    .rdData(rdData), .fullN(fullN), .almostFullN(almostFullN),
    .almostEmptyN(almostEmptyN), .emptyN(emptyN)
  );

  // Reference model: word counts, two-stage delayed views, a queue of words
  int wTotal, rTotal, rSeenA, rSeenB, wSeenA, wSeenB, xOff, yOff;
  logic [WIDTH-1:0] store[$];
  logic [WIDTH-1:0] expData;

  always @(posedge clk) begin
    if (!rstN) begin
      wTotal = 0; rTotal = 0; rSeenA = 0; rSeenB = 0; wSeenA = 0; wSeenB = 0;
      xOff = 8; yOff = 8; expData = '0; store.delete();
    end else begin
      bit wOk, rOk;
      wOk = wrEn && !offLoad && ((wTotal - rSeenB) < DEPTH);
      rOk = rdEn && ((wSeenB - rTotal) != 0);
      rSeenB = rSeenA; rSeenA = rTotal;
      wSeenB = wSeenA; wSeenA = wTotal;
      if (rOk) begin expData = store.pop_front(); rTotal++; end
      if (wOk) begin store.push_back(wrData); wTotal++; end
      if (offLoad) begin
        xOff = int'(wrData[AW-1:0]);
        yOff = int'(wrData[18+AW-1:18]);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: act=%0d exp=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      int wc, rc;
      wc = wTotal - rSeenB;
      rc = wSeenB - rTotal;
      check("R1 R2 fullN", fullN, wc < DEPTH);
      check("R5 R9 almostFullN", almostFullN, wc < DEPTH - yOff);
      check("R4 R9 almostEmptyN", almostEmptyN, rc > xOff);
      check("R6 emptyN", emptyN, rc != 0);
      compared++;
      if (rdData !== expData) begin
        mismatched++;
        $display("FAIL R3 R7 R10 rdData at %0t: act=%h exp=%h", $time, rdData, expData);
      end
    end
  end

  task automatic step(input logic we, input logic re, input logic ol, input logic [WIDTH-1:0] d);
    @(negedge clk);
    wrEn = we; rdEn = re; offLoad = ol; wrData = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values while held in reset
    check("R8 fullN", fullN, 1'b1);
    check("R8 emptyN", emptyN, 1'b0);
    check("R8 almostEmptyN", almostEmptyN, 1'b0);
    check("R8 almostFullN", almostFullN, 1'b1);
    compared++;
    if (rdData !== '0) begin
      mismatched++;
      $display("FAIL R8 rdData act=%h exp=0", rdData);
    end
    @(negedge clk) rstN = 1'b1;
    // R3 R4: writes cross the almost-empty threshold
    for (int i = 0; i < 20; i++) step(1, 0, 0, {$urandom, 4'h0} ^ WIDTH'(i));
    step(0, 0, 0, '0);
    // R6 R7: drain past empty, extra reads ignored
    for (int i = 0; i < 25; i++) step(0, 1, 0, '0);
    // R1: fill and push four more that must be discarded
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0, 0, WIDTH'($urandom) ^ (WIDTH'(i) << 20));
    // R2: one read, then watch the full flag release
    step(0, 1, 0, '0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, '0);
    for (int i = 0; i < 3; i++) step(1, 0, 0, WIDTH'(36'h5A5A0000 + i));
    // R6: drain fully
    for (int i = 0; i < DEPTH + 6; i++) step(0, 1, 0, '0);
    // R9: X = 3, Y = 250 in one load, then simultaneous traffic
    step(0, 0, 1, (WIDTH'(250) << 18) | WIDTH'(3));
    for (int i = 0; i < 1500; i++)
      step(($urandom % 10) < 6, ($urandom % 10) < 5, 0, {$urandom, 4'hC});
    step(0, 0, 1, (WIDTH'(20) << 18) | WIDTH'(30));
    for (int i = 0; i < 1500; i++)
      step(($urandom % 10) < 5, ($urandom % 10) < 6, 0, {$urandom, 4'h3});
    step(0, 0, 0, '0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule